// File: doc/BRIEF.md
# Dynamic Bus-Sizing Memory Controller

This block sits between a 32-bit processor request port and a shared external bus whose data path is 16 bits wide, of which 8-bit devices use only the low byte. Each processor request names a word address and a 4-bit byte mask. The block decodes the address into one of four chip-select regions, each with a fixed device width. It then runs one narrow bus cycle per halfword or byte that the mask touches, and gathers the read data back into a 32-bit word.

Each region has its own wait count from 0 to 7. Every narrow bus cycle is held for that many extra clocks. The counts live in small configuration registers that the processor reaches through a 1 MB window of the same address map. One of those registers also carries an unlock bit. While that bit is clear, the boot ROM region refuses writes: the request is acknowledged, no write strobe reaches the device, and a sticky fault output rises. Addresses outside every region are acknowledged at once.

Top module: `bsz_memctl`

## Requirements
- R1: Address decode. Any request with a nonzero address bit in 31:24 is unmapped. Otherwise bits 23:21 pick the region:
  - 0 is ROM, 16-bit, `bus_sel[0]`.
  - 1 is RAM, 8-bit, `bus_sel[1]`.
  - 2 is the configuration window, valid only while bit 20 is 0.
  - 3 is external select A, 8-bit, `bus_sel[2]`.
  - 4 is external select B, 8-bit, `bus_sel[3]`.
  - 5 is a reserved select treated as unmapped.
  - All other codes are unmapped.
  - At most one `bus_sel` bit is high, and only during a bus cycle.
- R2: On the 16-bit region, a word request at word address A runs the halfword at A (CPU bytes 1:0) before the halfword at A+2 (CPU bytes 3:2). Write data leaves on `bus_wdata[15:0]` and `bus_ben` carries the byte mask of that halfword.
- R3: On 8-bit regions, bytes go out in ascending order at A, A+1, A+2, A+3 on `bus_wdata[7:0]` with `bus_ben`=01. Read bytes are taken from `bus_rdata[7:0]`, and the upper input byte is ignored.
- R4: Only the bus cycles that cover enabled bytes are issued. Read bytes whose enable is clear return zero. A mask of zero completes one cycle after acceptance with no bus cycle.
- R5: Each bus cycle holds its strobes and address for W+1 clocks, where W is the region's wait count. `cpu_ready` rises N*(W+1)+1 clocks after the accepting edge for N bus cycles.
- R6: Configuration register k sits at window offset 4k, with bits 3:2 of the address selecting it: 0 is ROM, 1 is RAM, 2 is select A, 3 is select B. Bits 2:0 hold the wait count. Bit 3 of register 0 is the ROM unlock bit. A write takes effect only when `cpu_be[1:0]` is nonzero. Reads return the register zero-extended. Either access completes one cycle after acceptance.
- R7: After reset every wait count is 7, the unlock bit is 0, `rom_wp_fault` is 0, and no strobe, select or ready is active.
- R8: A write to ROM while the unlock bit is 0 completes one cycle after acceptance without any bus cycle and sets `rom_wp_fault`, which stays set until reset.
- R9: With the unlock bit set, ROM writes run normal bus cycles with the write strobe.
- R10: Unmapped requests complete one cycle after acceptance, read as zero, and cause no bus cycle.
- R11: A request is accepted on a clock edge while the controller is idle and `cpu_valid` is high. `cpu_ready` is a one-clock pulse, and `cpu_rdata` is valid only during it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | Request present; held until `cpu_ready` |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address; bits 1:0 ignored |
| cpu_be | input | 4 | Byte enables of the 32-bit word |
| cpu_wdata | input | 32 | Write data |
| cpu_ready | output | 1 | One-clock completion pulse |
| cpu_rdata | output | 32 | Read data, valid with `cpu_ready` |
| bus_sel | output | 4 | Region selects: ROM, RAM, select A, select B |
| bus_addr | output | 24 | Byte address of the current bus cycle |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_ben | output | 2 | Byte enables of the bus cycle |
| bus_wdata | output | 16 | Bus write data |
| bus_rdata | input | 16 | Bus read data |
| rom_wp_fault | output | 1 | Sticky flag for a refused ROM write |

## Verification
The due cycle of each result is fixed by the rule in R5. The bench drives a request on a falling edge and counts falling edges until `cpu_ready` is seen. It compares that count with N*(W+1)+1, or with 1 for configuration, unmapped, empty-mask and refused requests, and it samples `cpu_rdata` in that same half-cycle.

A falling-edge monitor records each distinct bus cycle: its address, data, byte enables and how many clocks it lasted. From that record the bench checks ordering, lane use and wait stretching without sampling at the edge where the design's outputs change.

// File: rtl/memctl_pkg.sv
package memctl_pkg;

    localparam int CPU_AW  = 32;
    localparam int CPU_DW  = 32;
    localparam int BUS_AW  = 24;
    localparam int BUS_DW  = 16;
    localparam int NLANE   = CPU_DW / 8;
    localparam int SLOT_LSB = 21;
    localparam int SLOT_W   = BUS_AW - SLOT_LSB;

    localparam logic [SLOT_W-1:0] SLOT_ROM   = 3'd0;
    localparam logic [SLOT_W-1:0] SLOT_RAM   = 3'd1;
    localparam logic [SLOT_W-1:0] SLOT_CFG   = 3'd2;
    localparam logic [SLOT_W-1:0] SLOT_EXTA  = 3'd3;
    localparam logic [SLOT_W-1:0] SLOT_EXTB  = 3'd4;
    localparam logic [SLOT_W-1:0] SLOT_SPARE = 3'd5;

    // The two low bits of the external regions double as select and wait index.
    typedef enum logic [2:0] {
        RG_ROM  = 3'd0,
        RG_RAM  = 3'd1,
        RG_EXTA = 3'd2,
        RG_EXTB = 3'd3,
        RG_CFG  = 3'd4,
        RG_NONE = 3'd5
    } region_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUS  = 2'd1,
        ST_DONE = 2'd2
    } state_e;

    // Which narrow bus cycles a byte mask needs.
    function automatic logic [NLANE-1:0] unit_mask(input logic [NLANE-1:0] be,
                                                   input logic narrow);
        logic [NLANE-1:0] m;
        if (narrow) begin
            m = be;
        end else begin
            m = {2'b00, |be[3:2], |be[1:0]};
        end
        return m;
    endfunction

    // Lowest pending unit index.
    function automatic logic [1:0] low_unit(input logic [NLANE-1:0] m);
        logic [1:0] u;
        u = 2'd0;
        for (int i = NLANE - 1; i >= 0; i--) begin
            if (m[i]) begin
                u = 2'(i);
            end
        end
        return u;
    endfunction

endpackage

// File: rtl/memctl_decode.sv
module memctl_decode
    import memctl_pkg::*;
#(
    parameter int HI_LSB = 20
) (
    input  logic [CPU_AW-1:HI_LSB] addr_hi,
    output region_e                region,
    output logic                   narrow
);

    logic [SLOT_W-1:0] slot;
    logic              upper_zero;

    assign slot       = addr_hi[BUS_AW-1:SLOT_LSB];
    assign upper_zero = (addr_hi[CPU_AW-1:BUS_AW] == '0);

    always_comb begin
        region = RG_NONE;
        if (upper_zero) begin
            case (slot)
                SLOT_ROM:   region = RG_ROM;
                SLOT_RAM:   region = RG_RAM;
                SLOT_CFG:   region = addr_hi[HI_LSB] ? RG_NONE : RG_CFG;
                SLOT_EXTA:  region = RG_EXTA;
                SLOT_EXTB:  region = RG_EXTB;
                SLOT_SPARE: region = RG_NONE;
                default:    region = RG_NONE;
            endcase
        end
    end

    assign narrow = (region == RG_RAM) || (region == RG_EXTA) || (region == RG_EXTB);

endmodule

// File: rtl/memctl_cfg.sv
module memctl_cfg #(
    parameter int NREG     = 4,
    parameter int WAIT_W   = 3,
    parameter int RST_WAIT = 7,
    localparam int IDX_W   = $clog2(NREG),
    localparam int RD_W    = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we,
    input  logic [IDX_W-1:0]            widx,
    input  logic [WAIT_W:0]             wdata,
    input  logic [IDX_W-1:0]            ridx,
    output logic [NREG-1:0][WAIT_W-1:0] waits,
    output logic                        fwe,
    output logic [RD_W-1:0]             rdata
);

    logic [WAIT_W-1:0] wq [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                wq[g] <= WAIT_W'(RST_WAIT);
            end else if (we && (widx == IDX_W'(g))) begin
                wq[g] <= wdata[WAIT_W-1:0];
            end
        end
        assign waits[g] = wq[g];
    end

    // Unlock bit sits just above the wait field of register 0.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fwe <= 1'b0;
        end else if (we && (widx == '0)) begin
            fwe <= wdata[WAIT_W];
        end
    end

    always_comb begin
        rdata = '0;
        rdata[WAIT_W-1:0] = wq[ridx];
        if (ridx == '0) begin
            rdata[WAIT_W] = fwe;
        end
    end

endmodule

// File: rtl/bsz_memctl.sv
module bsz_memctl
    import memctl_pkg::*;
#(
    parameter int WAIT_W   = 3,
    parameter int RST_WAIT = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_valid,
    input  logic              cpu_write,
    input  logic [31:0]       cpu_addr,
    input  logic [3:0]        cpu_be,
    input  logic [31:0]       cpu_wdata,
    output logic              cpu_ready,
    output logic [31:0]       cpu_rdata,
    output logic [3:0]        bus_sel,
    output logic [23:0]       bus_addr,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic [1:0]        bus_ben,
    output logic [15:0]       bus_wdata,
    input  logic [15:0]       bus_rdata,
    output logic              rom_wp_fault
);

    localparam int NREG   = 4;
    localparam int IDX_W  = $clog2(NREG);
    localparam int UNIT_W = $clog2(NLANE);
    localparam int DEC_LSB = 20;

    state_e state_q, state_d;

    // Decode of the incoming request
    region_e dec_rg;
    logic    dec_narrow;

    memctl_decode #(.HI_LSB(DEC_LSB)) u_dec (
        .addr_hi (cpu_addr[CPU_AW-1:DEC_LSB]),
        .region  (dec_rg),
        .narrow  (dec_narrow)
    );

    // Configuration registers
    logic                        cfg_we;
    logic [NREG-1:0][WAIT_W-1:0] cfg_waits;
    logic                        cfg_fwe;
    logic [15:0]                 cfg_rdata;

    memctl_cfg #(.NREG(NREG), .WAIT_W(WAIT_W), .RST_WAIT(RST_WAIT)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .widx  (cpu_addr[IDX_W+1:2]),
        .wdata (cpu_wdata[WAIT_W:0]),
        .ridx  (cpu_addr[IDX_W+1:2]),
        .waits (cfg_waits),
        .fwe   (cfg_fwe),
        .rdata (cfg_rdata)
    );

    // Acceptance terms
    logic             accept;
    logic             acc_ext;
    logic             acc_block;
    logic             acc_go;
    logic [NLANE-1:0] acc_mask;

    assign accept    = (state_q == ST_IDLE) && cpu_valid;
    assign acc_ext   = (dec_rg == RG_ROM) || (dec_rg == RG_RAM) ||
                       (dec_rg == RG_EXTA) || (dec_rg == RG_EXTB);
    assign acc_block = (dec_rg == RG_ROM) && cpu_write && !cfg_fwe;
    assign acc_mask  = unit_mask(cpu_be, dec_narrow);
    assign acc_go    = acc_ext && !acc_block && (acc_mask != '0);
    assign cfg_we    = accept && cpu_write && (dec_rg == RG_CFG) && (|cpu_be[1:0]);

    // Transfer state
    logic              wr_q;
    region_e           rg_q;
    logic              narrow_q;
    logic [23:0]       base_q;
    logic [3:0]        be_q;
    logic [31:0]       wd_q;
    logic [NLANE-1:0]  rem_q;
    logic [UNIT_W-1:0] unit_q;
    logic [WAIT_W-1:0] cnt_q;
    logic [WAIT_W-1:0] wait_q;
    logic [31:0]       rbuf_q;
    logic              fault_q;

    logic              unit_done;
    logic [NLANE-1:0]  rem_after;
    logic [NLANE-1:0]  cap_en;
    logic [31:0]       cap_data;

    assign unit_done = (state_q == ST_BUS) && (cnt_q == '0);
    assign rem_after = rem_q & ~(NLANE'(1) << unit_q);

    always_comb begin
        if (narrow_q) begin
            cap_en   = (NLANE'(1) << unit_q) & be_q;
            cap_data = {4{bus_rdata[7:0]}};
        end else begin
            cap_en   = (unit_q[0] ? 4'b1100 : 4'b0011) & be_q;
            cap_data = {2{bus_rdata}};
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d = acc_go ? ST_BUS : ST_DONE;
                end
            end
            ST_BUS: begin
                if (unit_done && (rem_after == '0)) begin
                    state_d = ST_DONE;
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q     <= 1'b0;
            rg_q     <= RG_NONE;
            narrow_q <= 1'b0;
            base_q   <= '0;
            be_q     <= '0;
            wd_q     <= '0;
            rem_q    <= '0;
            unit_q   <= '0;
            cnt_q    <= '0;
            wait_q   <= '0;
            rbuf_q   <= '0;
            fault_q  <= 1'b0;
        end else begin
            if (accept) begin
                wr_q     <= cpu_write;
                rg_q     <= dec_rg;
                narrow_q <= dec_narrow;
                base_q   <= cpu_addr[23:0] & 24'hFF_FFFC;
                be_q     <= cpu_be;
                wd_q     <= cpu_wdata;
                rem_q    <= acc_mask;
                unit_q   <= low_unit(acc_mask);
                wait_q   <= cfg_waits[dec_rg[1:0]];
                cnt_q    <= cfg_waits[dec_rg[1:0]];
                rbuf_q   <= ((dec_rg == RG_CFG) && !cpu_write) ? {16'h0000, cfg_rdata} : '0;
                if (acc_block) begin
                    fault_q <= 1'b1;
                end
            end
            if (unit_done) begin
                for (int b = 0; b < NLANE; b++) begin
                    if (cap_en[b] && !wr_q) begin
                        rbuf_q[8*b +: 8] <= cap_data[8*b +: 8];
                    end
                end
                rem_q <= rem_after;
                if (rem_after != '0) begin
                    unit_q <= low_unit(rem_after);
                    cnt_q  <= wait_q;
                end
            end else if (state_q == ST_BUS) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        cpu_ready = 1'b0;
        cpu_rdata = '0;
        bus_sel   = '0;
        bus_addr  = '0;
        bus_rd    = 1'b0;
        bus_wr    = 1'b0;
        bus_ben   = '0;
        bus_wdata = '0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_BUS: begin
                bus_sel[rg_q[1:0]] = 1'b1;
                bus_rd = !wr_q;
                bus_wr = wr_q;
                if (narrow_q) begin
                    bus_addr = base_q + 24'(unit_q);
                    bus_ben  = 2'b01;
                    if (wr_q) begin
                        bus_wdata = {8'h00, wd_q[8*unit_q +: 8]};
                    end
                end else begin
                    bus_addr = base_q + (24'(unit_q[0]) << 1);
                    bus_ben  = be_q[2*unit_q[0] +: 2];
                    if (wr_q) begin
                        bus_wdata = wd_q[16*unit_q[0] +: 16];
                    end
                end
            end
            ST_DONE: begin
                cpu_ready = 1'b1;
                cpu_rdata = rbuf_q;
            end
            default: begin
            end
        endcase
    end

    assign rom_wp_fault = fault_q;

endmodule

// File: rtl/memctl_chk.sv
module memctl_chk #(
    parameter int WAIT_W = 3
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cpu_ready,
    input logic [3:0]  bus_sel,
    input logic        bus_rd,
    input logic        bus_wr,
    input logic [23:0] bus_addr,
    input logic        rom_wp_fault,
    input logic        fwe
);

    localparam int MAXRUN = 1 << WAIT_W;
    localparam int RUN_W  = WAIT_W + 2;

    logic             strobe;
    logic             prev_strobe;
    logic [23:0]      prev_addr;
    logic [RUN_W-1:0] run;

    assign strobe = bus_rd || bus_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_strobe <= 1'b0;
            prev_addr   <= '0;
            run         <= '0;
        end else begin
            prev_strobe <= strobe;
            prev_addr   <= bus_addr;
            if (strobe && prev_strobe && (bus_addr == prev_addr)) begin
                run <= run + 1'b1;
            end else begin
                run <= strobe ? RUN_W'(1) : '0;
            end
        end
    end

    a_r11_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);

    a_r1_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bus_sel));

    a_r1_strobe_has_sel: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd || bus_wr) |-> ((bus_sel != 4'b0000) && !(bus_rd && bus_wr)));

    a_r5_no_strobe_at_ready: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> !(bus_rd || bus_wr));

    a_r5_hold_bound: assert property (@(posedge clk) disable iff (!rst_n)
        run <= RUN_W'(MAXRUN));

    a_r8_locked_rom: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_sel[0]) |-> fwe);

    a_r8_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        rom_wp_fault |=> rom_wp_fault);

endmodule

bind bsz_memctl memctl_chk #(.WAIT_W(WAIT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_ready    (cpu_ready),
    .bus_sel      (bus_sel),
    .bus_rd       (bus_rd),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .rom_wp_fault (rom_wp_fault),
    .fwe          (cfg_fwe)
);

// File: tb/bsz_memctl_tb.sv
module bsz_memctl_tb;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_valid = 1'b0;
    logic        cpu_write = 1'b0;
    logic [31:0] cpu_addr = '0;
    logic [3:0]  cpu_be = '0;
    logic [31:0] cpu_wdata = '0;
    logic        cpu_ready;
    logic [31:0] cpu_rdata;
    logic [3:0]  bus_sel;
    logic [23:0] bus_addr;
    logic        bus_rd;
    logic        bus_wr;
    logic [1:0]  bus_ben;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata;
    logic        rom_wp_fault;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_P/2) clk = ~clk;

    bsz_memctl u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_write(cpu_write),
        .cpu_addr(cpu_addr), .cpu_be(cpu_be), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata), .bus_sel(bus_sel),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_ben(bus_ben),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rom_wp_fault(rom_wp_fault)
    );

    // Device model: ROM returns {addr^A5, addr}; byte devices return addr in the low byte.
    assign bus_rdata = bus_sel[0] ? {bus_addr[7:0] ^ 8'hA5, bus_addr[7:0]}
                                  : {8'hEE, bus_addr[7:0]};

    // Bus-cycle monitor
    int          lg_n = 0;
    logic [23:0] lg_addr [64];
    logic [15:0] lg_wd   [64];
    logic [1:0]  lg_ben  [64];
    logic [3:0]  lg_sel  [64];
    int          lg_dur  [64];
    logic        pv_s = 1'b0;
    logic [23:0] pv_a = '0;

    always @(negedge clk) begin
        if (bus_rd || bus_wr) begin
            if (!pv_s || (bus_addr != pv_a)) begin
                lg_n = lg_n + 1;
                lg_addr[lg_n & 63] = bus_addr;
                lg_wd[lg_n & 63]   = bus_wdata;
                lg_ben[lg_n & 63]  = bus_ben;
                lg_sel[lg_n & 63]  = bus_sel;
                lg_dur[lg_n & 63]  = 1;
            end else begin
                lg_dur[lg_n & 63] = lg_dur[lg_n & 63] + 1;
            end
        end
        pv_s = bus_rd || bus_wr;
        pv_a = bus_addr;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    int req_start;

    task automatic req(input logic wr, input logic [31:0] addr, input logic [3:0] be,
                       input logic [31:0] wd, output logic [31:0] rd, output int lat,
                       output int units);
        @(negedge clk);
        req_start = lg_n;
        cpu_valid = 1'b1;
        cpu_write = wr;
        cpu_addr  = addr;
        cpu_be    = be;
        cpu_wdata = wd;
        lat = 0;
        rd  = '0;
        forever begin
            @(negedge clk);
            lat++;
            if (cpu_ready) begin
                rd = cpu_rdata;
                break;
            end
            if (lat > 200) begin
                check("R11 request never completed", 32'(lat), 32'd0);
                break;
            end
        end
        cpu_valid = 1'b0;
        units = lg_n - req_start;
    endtask

    typedef struct packed {
        logic        wr;
        logic [31:0] addr;
        logic [3:0]  be;
        logic [31:0] wd;
        logic [31:0] exp_rd;
        logic [2:0]  units;
        logic [23:0] first;
        logic [7:0]  lat;
    } vec_t;

    localparam int NV = 13;
    // Waits in force for the table: ROM 1, RAM 0, select A 2, select B 7.
    localparam vec_t VECS [NV] = '{
        '{1'b0, 32'h0000_0010, 4'hF, 32'h0, 32'hB712_B510, 3'd2, 24'h000010, 8'd5},
        '{1'b0, 32'h0000_0020, 4'hC, 32'h0, 32'h8722_0000, 3'd1, 24'h000022, 8'd3},
        '{1'b0, 32'h0020_0040, 4'hF, 32'h0, 32'h4342_4140, 3'd4, 24'h200040, 8'd5},
        '{1'b0, 32'h0020_0044, 4'hA, 32'h0, 32'h4700_4500, 3'd2, 24'h200045, 8'd3},
        '{1'b0, 32'h0060_0008, 4'h1, 32'h0, 32'h0000_0008, 3'd1, 24'h600008, 8'd4},
        '{1'b0, 32'h0080_0000, 4'h3, 32'h0, 32'h0000_0100, 3'd2, 24'h800000, 8'd17},
        '{1'b0, 32'h00C0_0000, 4'hF, 32'h0, 32'h0, 3'd0, 24'h0, 8'd1},
        '{1'b0, 32'h00A0_0000, 4'hF, 32'h0, 32'h0, 3'd0, 24'h0, 8'd1},
        '{1'b0, 32'h0100_0000, 4'hF, 32'h0, 32'h0, 3'd0, 24'h0, 8'd1},
        '{1'b1, 32'h0020_0100, 4'hF, 32'hDDCC_BBAA, 32'h0, 3'd4, 24'h200100, 8'd5},
        '{1'b1, 32'h00C0_0010, 4'hF, 32'h1111_1111, 32'h0, 3'd0, 24'h0, 8'd1},
        '{1'b0, 32'h0020_0050, 4'h0, 32'h0, 32'h0, 3'd0, 24'h0, 8'd1},
        '{1'b0, 32'h0050_0000, 4'hF, 32'h0, 32'h0, 3'd0, 24'h0, 8'd1}
    };

    initial begin : wdog
        #(CLK_P * 150000);
        n_chk++;
        n_err++;
        $display("FAIL R11 watchdog expired actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin : main
        logic [31:0] rd;
        int lat;
        int un;
        int b;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R7 reset state
        check("R7 ready after reset", 32'(cpu_ready), 32'd0);
        check("R7 strobes after reset", {30'd0, bus_rd, bus_wr}, 32'd0);
        check("R7 selects after reset", 32'(bus_sel), 32'd0);
        check("R7 fault after reset", 32'(rom_wp_fault), 32'd0);

        // R6/R7 default configuration
        for (int k = 0; k < 4; k++) begin
            req(1'b0, 32'h0040_0000 + 32'(4*k), 4'hF, 32'h0, rd, lat, un);
            check("R7 default wait readback", rd, 32'd7);
            check("R6 config read latency", 32'(lat), 32'd1);
        end

        // R6 programming
        req(1'b1, 32'h0040_0000, 4'h1, 32'h1, rd, lat, un);
        check("R6 config write latency", 32'(lat), 32'd1);
        req(1'b1, 32'h0040_0004, 4'h3, 32'h0, rd, lat, un);
        req(1'b1, 32'h0040_0008, 4'h1, 32'h2, rd, lat, un);
        req(1'b0, 32'h0040_0008, 4'hF, 32'h0, rd, lat, un);
        check("R6 select A wait readback", rd, 32'd2);
        req(1'b1, 32'h0040_0004, 4'hC, 32'h5, rd, lat, un);
        req(1'b0, 32'h0040_0004, 4'hF, 32'h0, rd, lat, un);
        check("R6 write with be[1:0]=0 ignored", rd, 32'd0);
        check("R6 config access no bus cycle", 32'(un), 32'd0);

        // Table walk: R1 R2 R3 R4 R5 R10
        for (int i = 0; i < NV; i++) begin
            req(VECS[i].wr, VECS[i].addr, VECS[i].be, VECS[i].wd, rd, lat, un);
            if (!VECS[i].wr) begin
                check($sformatf("R2 R3 R4 R10 vector %0d read data", i), rd, VECS[i].exp_rd);
            end
            check($sformatf("R4 vector %0d bus cycle count", i), 32'(un), 32'(VECS[i].units));
            check($sformatf("R5 vector %0d latency", i), 32'(lat), 32'(VECS[i].lat));
            if (VECS[i].units != 0) begin
                check($sformatf("R1 vector %0d first address", i),
                      32'(lg_addr[(req_start + 1) & 63]), 32'(VECS[i].first));
            end
        end

        // R1 select lines per region
        req(1'b0, 32'h0060_0000, 4'h1, 32'h0, rd, lat, un);
        check("R1 select A line", 32'(lg_sel[lg_n & 63]), 32'h4);
        req(1'b0, 32'h0080_0004, 4'h1, 32'h0, rd, lat, un);
        check("R1 select B line", 32'(lg_sel[lg_n & 63]), 32'h8);
        check("R5 wait 7 holds 8 clocks", 32'(lg_dur[lg_n & 63]), 32'd8);
        check("R5 wait 7 single byte latency", 32'(lat), 32'd9);
        req(1'b0, 32'h0020_0000, 4'h1, 32'h0, rd, lat, un);
        check("R1 RAM line", 32'(lg_sel[lg_n & 63]), 32'h2);
        check("R5 wait 0 holds 1 clock", 32'(lg_dur[lg_n & 63]), 32'd1);

        // R3 byte write order
        req(1'b1, 32'h0020_0200, 4'hF, 32'hDDCC_BBAA, rd, lat, un);
        check("R3 byte write count", 32'(un), 32'd4);
        for (int u = 0; u < 4; u++) begin
            b = (req_start + 1 + u) & 63;
            check("R3 byte write address", 32'(lg_addr[b]), 32'h0020_0200 + 32'(u));
            check("R3 byte write data", 32'(lg_wd[b]), 32'((32'hDDCC_BBAA >> (8*u)) & 32'hFF));
            check("R3 byte write enable", 32'(lg_ben[b]), 32'd1);
        end

        // R8 locked ROM write
        req(1'b1, 32'h0000_0200, 4'hF, 32'hCAFE_F00D, rd, lat, un);
        check("R8 locked write latency", 32'(lat), 32'd1);
        check("R8 locked write no bus cycle", 32'(un), 32'd0);
        check("R8 fault set", 32'(rom_wp_fault), 32'd1);
        req(1'b0, 32'h0020_0000, 4'h1, 32'h0, rd, lat, un);
        check("R8 fault sticky", 32'(rom_wp_fault), 32'd1);

        // R9 unlock, then partial and full ROM writes
        req(1'b1, 32'h0040_0000, 4'h1, 32'h9, rd, lat, un);
        req(1'b0, 32'h0040_0000, 4'hF, 32'h0, rd, lat, un);
        check("R6 unlock bit readback", rd, 32'h9);
        req(1'b1, 32'h0000_0300, 4'h4, 32'h00AB_0000, rd, lat, un);
        check("R9 partial ROM write count", 32'(un), 32'd1);
        check("R9 partial ROM write address", 32'(lg_addr[lg_n & 63]), 32'h0000_0302);
        check("R9 partial ROM write enables", 32'(lg_ben[lg_n & 63]), 32'd1);
        check("R9 partial ROM write data", 32'(lg_wd[lg_n & 63]), 32'h0000_00AB);
        check("R9 partial ROM write latency", 32'(lat), 32'd3);
        req(1'b1, 32'h0000_0400, 4'hF, 32'h1234_5678, rd, lat, un);
        check("R2 halfword write count", 32'(un), 32'd2);
        check("R2 low halfword first addr", 32'(lg_addr[(req_start + 1) & 63]), 32'h400);
        check("R2 low halfword first data", 32'(lg_wd[(req_start + 1) & 63]), 32'h5678);
        check("R2 low halfword enables", 32'(lg_ben[(req_start + 1) & 63]), 32'h3);
        check("R2 high halfword addr", 32'(lg_addr[(req_start + 2) & 63]), 32'h402);
        check("R2 high halfword data", 32'(lg_wd[(req_start + 2) & 63]), 32'h1234);
        check("R8 fault still set", 32'(rom_wp_fault), 32'd1);

        // R11 ready is a single pulse and idle follows
        @(negedge clk);
        check("R11 ready dropped", 32'(cpu_ready), 32'd0);

        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule